// File: doc/BRIEF.md
# Interrupt Enable/Status Unit

This block is the interrupt section of a memory-mapped register interface. Four event pulses come in from the rest of the design: data available, status valid, locality change and command ready. Each pulse sets its own sticky status bit. Software clears a status bit by writing a one to it. An enable register gates each source and also carries a master enable bit. A vector register holds the interrupt number that the host assigns. A fixed capability word tells software which sources and trigger styles are supported.

A single interrupt wire leaves the block. Two bits of the enable register choose its shape: active-high level, active-low level, a one-cycle high pulse, or a one-cycle low pulse on an idle-high line. The block does not decide when events happen. It only latches events, gates them and signals the result.

Top module: `irq_unit`

## Requirements
- R1: After reset the enable, status and vector registers read 0 and `irq_out` is 0. The capability register (offset 0x14) reads 0x000001FF at all times.
- R2: A one-cycle pulse on an event input sets its status bit, whether or not that source is enabled. The status bits are: data available at bit 0, status valid at bit 1, locality change at bit 2 and command ready at bit 7. Status is read at offset 0x10.
- R3: A write to offset 0x10 clears each status bit written as 1 and leaves bits written as 0 unchanged. If an event and a clear of the same bit fall in one cycle, the bit stays set.
- R4: While enable bit 31 is 0, no source has an effect on the output. In level-high mode `irq_out` then stays 0.
- R5: The pending condition is: bit 31 = 1 and (status AND enable) is nonzero. Enable bits 4:3 = 00 select level-high mode. In this mode `irq_out` equals the pending condition, delayed by one clock.
- R6: Enable bits 4:3 = 01 select level-low mode. In this mode `irq_out` is the inverse of the pending condition, delayed by one clock.
- R7: Enable bits 4:3 = 10 select rising mode. Each time the pending condition rises from 0 to 1, `irq_out` is high for exactly one cycle, one clock later.
- R8: Enable bits 4:3 = 11 select falling mode. `irq_out` idles high and drops for exactly one cycle, one clock after each 0-to-1 rise of the pending condition.
- R9: The vector register at offset 0x0C holds the low 4 bits of the last value written. The upper bits read 0.
- R10: Writes to the capability register have no effect on what it reads back.
- R11: The enable register at offset 0x08 stores only bits 31, 7, 4, 3, 2, 1 and 0; all other bits read 0. Status reads 0 outside bits 0, 1, 2 and 7. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_data_avail | input | 1 | Data-available event pulse |
| ev_sts_valid | input | 1 | Status-valid event pulse |
| ev_loc_change | input | 1 | Locality-change event pulse |
| ev_cmd_ready | input | 1 | Command-ready event pulse |
| irq_out | output | 1 | Interrupt line, shaped by the selected mode |

## Verification
Two things can happen to the same status bit in one cycle: a new event and a software write-one-to-clear. The bench provokes this by pulsing status valid in the same cycle as a write that clears bit 1. It then reads status back and expects bit 1 still set, while a bit cleared with no event present really does clear. A behavioural reference model runs alongside the design and is compared with `irq_out` on every clock. This also covers the cycle in which a mode change and a change of the pending condition coincide.

// File: rtl/irq_pkg.sv
// Shared constants for the interrupt unit: register offsets, source bit
// positions, writable masks and the output-mode encoding.
// Assumes a 32-bit register bus with byte offsets.
package irq_pkg;
    localparam int DATA_W   = 32;
    localparam int NSRC     = 4;
    localparam int OFS_EN   = 'h08;
    localparam int OFS_VEC  = 'h0C;
    localparam int OFS_STAT = 'h10;
    localparam int OFS_CAP  = 'h14;
    localparam int BIT_GIE  = 31;
    localparam int MODE_LSB = 3;
    localparam int SRC_POS [NSRC] = '{0, 1, 2, 7};
    localparam logic [DATA_W-1:0] SRC_MASK = 32'h0000_0087;
    localparam logic [DATA_W-1:0] EN_MASK  = 32'h8000_009F;
    localparam logic [DATA_W-1:0] CAP_WORD = 32'h0000_01FF;

    typedef enum logic [1:0] {
        MODE_LVL_HI = 2'b00,
        MODE_LVL_LO = 2'b01,
        MODE_RISE   = 2'b10,
        MODE_FALL   = 2'b11
    } irq_mode_e;
endpackage

// File: rtl/irq_regs.sv
// Enable and vector registers of the interrupt unit.
// Assumes a single-cycle write strobe; only mask bits of enable are stored.
module irq_regs
    import irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int VEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q,
    output logic [VEC_W-1:0]  vec_q
);
    // Enable register: stores writable bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr && addr == ADDR_W'(OFS_EN))
            en_q <= wdata & EN_MASK;
    end

    // Vector register: keeps the low bits of the last value written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (wr && addr == ADDR_W'(OFS_VEC))
            vec_q <= wdata[VEC_W-1:0];
    end
endmodule

// File: rtl/irq_status.sv
// Sticky per-source status bits with write-one-to-clear.
// Assumes a set and a clear in one cycle resolve to set.
module irq_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat_q
);
    for (genvar i = 0; i < N; i++) begin : g_src
        // One latched bit per source; event wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else if (ev[i])
                stat_q[i] <= 1'b1;
            else if (clr[i])
                stat_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_drive.sv
// Shapes the pending condition into the interrupt line for the chosen mode.
// Assumes pend is a registered-domain signal; output is registered.
module irq_drive
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pend,
    input  irq_mode_e mode,
    output logic      irq_out
);
    logic pend_d;
    logic rise;

    // Detect a 0-to-1 change of the pending condition.
    always_comb rise = pend && !pend_d;

    // Remember pending and register the shaped line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_d  <= 1'b0;
            irq_out <= 1'b0;
        end else begin
            pend_d <= pend;
            unique case (mode)
                MODE_LVL_HI: irq_out <= pend;
                MODE_LVL_LO: irq_out <= !pend;
                MODE_RISE:   irq_out <= rise;
                MODE_FALL:   irq_out <= !rise;
            endcase
        end
    end
endmodule

// File: rtl/irq_unit.sv
// Top of the interrupt unit: register decode, status latching, gating and
// line shaping. Assumes reads are combinational on the offset presented.
module irq_unit
    import irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int VEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_data_avail,
    input  logic              ev_sts_valid,
    input  logic              ev_loc_change,
    input  logic              ev_cmd_ready,
    output logic              irq_out
);
    logic [DATA_W-1:0] en_q;
    logic [VEC_W-1:0]  vec_q;
    logic [NSRC-1:0]   ev_vec;
    logic [NSRC-1:0]   clr_vec;
    logic [NSRC-1:0]   stat_q;
    logic [DATA_W-1:0] stat_word;
    logic              pend;
    irq_mode_e         mode;

    irq_regs #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .en_q(en_q), .vec_q(vec_q)
    );

    // Gather event pulses in source order.
    always_comb ev_vec = {ev_cmd_ready, ev_loc_change, ev_sts_valid, ev_data_avail};

    // Status clear strobes and status word at their bit positions.
    always_comb begin
        stat_word = '0;
        for (int i = 0; i < NSRC; i++) begin
            clr_vec[i] = reg_wr && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[SRC_POS[i]];
            stat_word[SRC_POS[i]] = stat_q[i];
        end
    end

    irq_status #(.N(NSRC)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(clr_vec), .stat_q(stat_q)
    );

    // Pending condition and mode selection from the enable register.
    always_comb begin
        pend = en_q[BIT_GIE] && |(stat_word & en_q & SRC_MASK);
        mode = irq_mode_e'(en_q[MODE_LSB +: 2]);
    end

    irq_drive u_drv (
        .clk(clk), .rst_n(rst_n), .pend(pend), .mode(mode), .irq_out(irq_out)
    );

    // Read mux over the mapped offsets.
    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFS_EN):   reg_rdata = en_q;
            ADDR_W'(OFS_VEC):  reg_rdata = DATA_W'(vec_q);
            ADDR_W'(OFS_STAT): reg_rdata = stat_word;
            ADDR_W'(OFS_CAP):  reg_rdata = CAP_WORD;
            default:           reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_unit_chk.sv
// Property checker for irq_unit, attached by bind.
module irq_unit_chk
    import irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              ev_data_avail,
    input logic [NSRC-1:0]   stat_q,
    input logic [DATA_W-1:0] en_q,
    input logic              pend,
    input logic              irq_out
);
    logic clr0;
    logic [1:0] md;
    always_comb begin
        clr0 = reg_wr && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[0];
        md   = en_q[MODE_LSB +: 2];
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_data_avail |=> stat_q[0]);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !ev_data_avail) |=> !stat_q[0]);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !clr0) |=> stat_q[0]);

    p_gie_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[BIT_GIE] && md == 2'b00) |=> !irq_out);

    p_level_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (md == 2'b00) |=> (irq_out == $past(pend)));

    p_level_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (md == 2'b01) |=> (irq_out == !$past(pend)));

    p_rise_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (md == 2'b10 && $past(md) == 2'b10 && irq_out) |=> !irq_out);
endmodule

bind irq_unit irq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ev_data_avail(ev_data_avail), .stat_q(stat_q),
    .en_q(en_q), .pend(pend), .irq_out(irq_out)
);

// File: tb/sim_irq_unit.sv
module sim_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  ev = '0;
    logic        irq_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_en = '0;
    logic [31:0] m_stat = '0;
    logic [3:0]  m_vec = '0;
    logic        m_prev = 0;
    logic        m_irq = 0;

    always #10 clk = ~clk;

    irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata),
        .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
        .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]), .irq_out(irq_out)
    );

    always @(posedge clk) begin
        logic p;
        logic r;
        if (!rst_n) begin
            m_en = '0; m_stat = '0; m_vec = '0; m_prev = 0; m_irq = 0;
        end else begin
            p = m_en[31] && ((m_stat & m_en & 32'h87) != 0);
            r = p && !m_prev;
            case (m_en[4:3])
                2'd0: m_irq = p;
                2'd1: m_irq = !p;
                2'd2: m_irq = r;
                default: m_irq = !r;
            endcase
            m_prev = p;
            if (wr && addr == 8'h10) m_stat = m_stat & ~(wdata & 32'h87);
            if (ev[0]) m_stat[0] = 1'b1;
            if (ev[1]) m_stat[1] = 1'b1;
            if (ev[2]) m_stat[2] = 1'b1;
            if (ev[3]) m_stat[7] = 1'b1;
            if (wr && addr == 8'h08) m_en = wdata & 32'h8000_009F;
            if (wr && addr == 8'h0C) m_vec = wdata[3:0];
        end
    end

    function automatic string mode_tag(logic [31:0] e);
        if (!e[31]) return "R4";
        case (e[4:3])
            2'd0: return "R5";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    // compare the line with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            nchk++;
            if (irq_out !== m_irq) begin
                nerr++;
                $display("FAIL %s irq_out actual %b expected %b at %0t",
                         mode_tag(m_en), irq_out, m_irq, $time);
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0; wdata = '0;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk); ev = m;
        @(negedge clk); ev = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); addr = a; #1;
        nchk++;
        if (rdata !== exp) begin
            nerr++;
            $display("FAIL %s read 0x%02h actual 0x%08h expected 0x%08h", tag, a, rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk); #1;
        nchk++;
        if (irq_out !== exp) begin
            nerr++;
            $display("FAIL %s irq_out actual %b expected %b", tag, irq_out, exp);
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        irq_chk(1'b0, "R1");
        rd_chk(8'h08, 32'h0, "R1");
        rd_chk(8'h10, 32'h0, "R1");
        rd_chk(8'h0C, 32'h0, "R1");
        rd_chk(8'h14, 32'h1FF, "R1");
        // R2 events latch with sources disabled
        pulse(4'b0001);
        rd_chk(8'h10, 32'h01, "R2");
        pulse(4'b1110);
        rd_chk(8'h10, 32'h87, "R2");
        // R3 write ones to clear
        wr_reg(8'h10, 32'h0000_0005);
        rd_chk(8'h10, 32'h82, "R3");
        // R3 set and clear in the same cycle of bit 1; bit 7 cleared alone
        @(negedge clk); ev = 4'b0010; wr = 1; addr = 8'h10; wdata = 32'h82;
        @(negedge clk); ev = '0; wr = 0; wdata = '0;
        rd_chk(8'h10, 32'h02, "R3");
        // R4 sources enabled but master off
        wr_reg(8'h08, 32'h0000_0087);
        idle(4);
        irq_chk(1'b0, "R4");
        // R5 level high
        wr_reg(8'h08, 32'h8000_0087);
        irq_chk(1'b1, "R5");
        wr_reg(8'h10, 32'h87);
        irq_chk(1'b0, "R5");
        pulse(4'b0100);
        irq_chk(1'b1, "R5");
        wr_reg(8'h10, 32'h04);
        // R6 level low
        wr_reg(8'h08, 32'h8000_008F);
        irq_chk(1'b1, "R6");
        pulse(4'b1000);
        irq_chk(1'b0, "R6");
        wr_reg(8'h10, 32'h80);
        idle(2);
        // R7 rising pulse
        wr_reg(8'h08, 32'h8000_0091);
        idle(2);
        pulse(4'b0001);
        idle(4);
        irq_chk(1'b0, "R7");
        wr_reg(8'h10, 32'h01);
        // R8 falling pulse
        wr_reg(8'h08, 32'h8000_0099);
        idle(2);
        irq_chk(1'b1, "R8");
        pulse(4'b0001);
        idle(4);
        irq_chk(1'b1, "R8");
        wr_reg(8'h10, 32'h01);
        // R11 writable masks
        wr_reg(8'h08, 32'hFFFF_FFFF);
        rd_chk(8'h08, 32'h8000_009F, "R11");
        wr_reg(8'h08, 32'h0);
        pulse(4'b1111);
        rd_chk(8'h10, 32'h87, "R11");
        rd_chk(8'h20, 32'h0, "R11");
        // R9 vector
        wr_reg(8'h0C, 32'hFFFF_FFFF);
        rd_chk(8'h0C, 32'h0000_000F, "R9");
        wr_reg(8'h0C, 32'h5);
        rd_chk(8'h0C, 32'h5, "R9");
        // R10 capability is read-only
        wr_reg(8'h14, 32'h0);
        rd_chk(8'h14, 32'h1FF, "R10");
        idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule